// File: doc/BRIEF.md
# Master Clock Divider with Quadrature Processor Clocks

This block takes one crystal-rate master clock and derives all the system timing from it in two stages. The first stage is a fixed divide-by-eight. It produces a square-wave colour-subcarrier reference for the video generator: about 3.58 MHz from a 28.64 MHz master, or the matching rate from a 28.475 MHz master. The second stage divides that reference again, by four at normal speed or by two at double speed. It produces the two processor clocks, E and Q, which are in quadrature. With the default settings, E runs at roughly 0.89 MHz or 1.78 MHz.

A speed-select input picks the second-stage divisor at run time. The block samples it only on the master-clock edge where E falls, so each half period of E and Q is always a whole half of one mode and never a runt. The block also exports a phase count: the number of master clocks elapsed in the current E half. A memory controller can use this count to place its row and column strobes inside each processor half and each video half.

Top module: `sysclk_eq_gen`

## Requirements
- R1: A clock edge that samples rst_n low leaves cref_o, e_o, q_o and phase_o at 0. While reset is held, the speed mode follows speed_i.
- R2: cref_o is a square wave with a period of 8 master clocks, high for 4 and low for 4.
- R3: With speed_i = 0, e_o has a period of 32 master clocks, high for 16 and low for 16. After rst_n is released with speed_i = 0, the first rise of e_o comes on the 16th master edge.
- R4: With speed_i = 1, e_o has a period of 16 master clocks, high for 8 and low for 8.
- R5: q_o has the same period and duty as e_o and leads it by a quarter period: it rises 8 master clocks (speed 0) or 4 master clocks (speed 1) before e_o rises, and falls the same number before e_o falls.
- R6: phase_o is 0 in the first master cycle of each e_o half and increases by 1 each master clock until that half ends.
- R7: A new speed_i value takes effect only at a falling edge of e_o. A change made during an E-high half, or just after E has fallen, leaves the running halves at the old length, so every e_o high or low run is exactly one half of a single mode.
- R8: The speed_i value sampled on the very edge where e_o falls governs the low half that starts at that edge.
- R9: Every edge of e_o falls in the same master cycle as a falling edge of cref_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock at crystal rate |
| rst_n | input | 1 | Synchronous reset, active low |
| speed_i | input | 1 | Speed select: 0 gives divide-by-4, 1 gives divide-by-2 |
| cref_o | output | 1 | Colour-subcarrier reference, master clock divided by 8 |
| e_o | output | 1 | Processor E clock |
| q_o | output | 1 | Processor Q clock, leading E by a quarter period |
| phase_o | output | 4 | Master clocks elapsed in the current E half |

## Verification
Two events can fall in the same master cycle: a change of speed select and the falling edge of E, where the period counter wraps and samples the speed. The bench provokes this by watching phase_o. In the last sample of an E-high half it flips speed_i, so the new value is set up for the exact edge where E falls. It then judges that the E-high half just ending kept its old length and that the low half starting at that edge already has the new one. Changes placed one cycle on either side of that edge show, by the same run-length measurement, that they wait for the next fall.

// File: rtl/clkgen_pkg.sv
// Shared types for the master clock divider.
// Assumes: speed select is a single bit, 0 = normal, 1 = double speed.
package clkgen_pkg;

    typedef enum logic {
        SPD_SLOW = 1'b0,
        SPD_FAST = 1'b1
    } speed_e;

endpackage

// File: rtl/cref_divider.sv
// Fixed divider producing the colour reference from the master clock.
// Output is registered and has 50% duty. Assumes DIV is even and at least 2.
module cref_divider #(
    parameter int DIV = 8
) (
    input  logic clk_m,
    input  logic rst_n,
    output logic cref_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALFV = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Next count: wrap to zero after the last master clock of a period.
    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Count register plus a glitch-free registered square wave.
    always_ff @(posedge clk_m) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cref_o <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            cref_o <= (cnt_nxt >= HALFV);
        end
    end

endmodule

// File: rtl/eq_phase_counter.sv
// Counts master clocks across one full E period and holds the speed mode.
// The mode is reloaded from speed_i only on the wrap, which is where E falls.
// Exposes next-state values so the decoder can register glitch-free outputs.
// Assumes PER_S >= PER_F and both are multiples of 4.
module eq_phase_counter
    import clkgen_pkg::*;
#(
    parameter int PER_S = 32,
    parameter int PER_F = 16,
    parameter int PW    = $clog2(PER_S)
) (
    input  logic          clk_m,
    input  logic          rst_n,
    input  logic          speed_i,
    output logic [PW-1:0] phase_nxt,
    output speed_e        mode_nxt
);
    localparam logic [PW-1:0] LAST_S = PW'(PER_S - 1);
    localparam logic [PW-1:0] LAST_F = PW'(PER_F - 1);

    logic [PW-1:0] phase_q;
    speed_e        mode_q;
    logic          wrap;

    // Next phase and mode: a mode change is only admitted on the wrap.
    always_comb begin
        wrap      = (phase_q == ((mode_q == SPD_FAST) ? LAST_F : LAST_S));
        phase_nxt = wrap ? '0 : phase_q + 1'b1;
        mode_nxt  = wrap ? speed_e'(speed_i) : mode_q;
    end

    // Phase and mode registers; during reset the mode tracks the input.
    always_ff @(posedge clk_m) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= speed_e'(speed_i);
        end else begin
            phase_q <= phase_nxt;
            mode_q  <= mode_nxt;
        end
    end

endmodule

// File: rtl/eq_decoder.sv
// Decodes the period phase into registered E, Q and a phase within the E half.
// Q is high in the middle two quarters of the period, E in the second half,
// so Q leads E by a quarter. Assumes the phase counter's next-state inputs.
module eq_decoder
    import clkgen_pkg::*;
#(
    parameter int PER_S = 32,
    parameter int PER_F = 16,
    parameter int PW    = $clog2(PER_S),
    parameter int HW    = $clog2(PER_S / 2)
) (
    input  logic          clk_m,
    input  logic          rst_n,
    input  logic [PW-1:0] phase_nxt,
    input  speed_e        mode_nxt,
    output logic          e_o,
    output logic          q_o,
    output logic [HW-1:0] phase_o
);
    logic [PW-1:0] half_len;
    logic [PW-1:0] qtr_len;
    logic          e_n;
    logic          q_n;
    logic [PW-1:0] hc_n;

    // Decode thresholds for the mode that governs the next cycle.
    always_comb begin
        half_len = (mode_nxt == SPD_FAST) ? PW'(PER_F / 2) : PW'(PER_S / 2);
        qtr_len  = (mode_nxt == SPD_FAST) ? PW'(PER_F / 4) : PW'(PER_S / 4);
        e_n      = (phase_nxt >= half_len);
        q_n      = (phase_nxt >= qtr_len) && (phase_nxt < (half_len + qtr_len));
        hc_n     = e_n ? (phase_nxt - half_len) : phase_nxt;
    end

    // Output registers, cleared low by reset.
    always_ff @(posedge clk_m) begin
        if (!rst_n) begin
            e_o     <= 1'b0;
            q_o     <= 1'b0;
            phase_o <= '0;
        end else begin
            e_o     <= e_n;
            q_o     <= q_n;
            phase_o <= HW'(hc_n);
        end
    end

endmodule

// File: rtl/sysclk_eq_gen.sv
// Top of the master clock divider: colour reference plus quadrature E/Q.
// Assumes CREF_DIV is even and CREF_DIV*FAST_DIV is a multiple of 4,
// with SLOW_DIV >= FAST_DIV. Both stages restart together on reset,
// so E edges always land on colour reference falling edges.
module sysclk_eq_gen #(
    parameter int CREF_DIV = 8,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic                                   clk_m,
    input  logic                                   rst_n,
    input  logic                                   speed_i,
    output logic                                   cref_o,
    output logic                                   e_o,
    output logic                                   q_o,
    output logic [$clog2(CREF_DIV*SLOW_DIV/2)-1:0] phase_o
);
    localparam int PER_S = CREF_DIV * SLOW_DIV;
    localparam int PER_F = CREF_DIV * FAST_DIV;
    localparam int PW    = $clog2(PER_S);
    localparam int HW    = $clog2(PER_S / 2);

    logic [PW-1:0]           phase_nxt;
    clkgen_pkg::speed_e      mode_nxt;

    cref_divider #(
        .DIV (CREF_DIV)
    ) u_cref (
        .clk_m  (clk_m),
        .rst_n  (rst_n),
        .cref_o (cref_o)
    );

    eq_phase_counter #(
        .PER_S (PER_S),
        .PER_F (PER_F),
        .PW    (PW)
    ) u_phase (
        .clk_m     (clk_m),
        .rst_n     (rst_n),
        .speed_i   (speed_i),
        .phase_nxt (phase_nxt),
        .mode_nxt  (mode_nxt)
    );

    eq_decoder #(
        .PER_S (PER_S),
        .PER_F (PER_F),
        .PW    (PW),
        .HW    (HW)
    ) u_dec (
        .clk_m     (clk_m),
        .rst_n     (rst_n),
        .phase_nxt (phase_nxt),
        .mode_nxt  (mode_nxt),
        .e_o       (e_o),
        .q_o       (q_o),
        .phase_o   (phase_o)
    );

endmodule

// File: rtl/sysclk_eq_chk.sv
// Property checker for sysclk_eq_gen, attached by bind below.
// Measures run lengths with its own counters, so no deep $past is needed.
module sysclk_eq_chk #(
    parameter int CREF_DIV = 8,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2,
    parameter int HW       = 4
) (
    input logic          clk_m,
    input logic          rst_n,
    input logic          cref_o,
    input logic          e_o,
    input logic          q_o,
    input logic [HW-1:0] phase_o
);
    localparam int HALF_S = CREF_DIV * SLOW_DIV / 2;
    localparam int HALF_F = CREF_DIV * FAST_DIV / 2;
    localparam int HALF_C = CREF_DIV / 2;

    logic       e_d;
    logic       e_arm;
    logic [7:0] e_len;
    logic       c_d;
    logic       c_arm;
    logic [7:0] c_len;

    // Run-length trackers for E and the colour reference.
    always_ff @(posedge clk_m) begin
        if (!rst_n) begin
            e_d   <= 1'b0;
            e_arm <= 1'b0;
            e_len <= '0;
            c_d   <= 1'b0;
            c_arm <= 1'b0;
            c_len <= '0;
        end else begin
            e_d   <= e_o;
            c_d   <= cref_o;
            e_len <= (e_o != e_d) ? 8'd1 : e_len + 8'd1;
            c_len <= (cref_o != c_d) ? 8'd1 : c_len + 8'd1;
            if (e_o != e_d)     e_arm <= 1'b1;
            if (cref_o != c_d)  c_arm <= 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_m)
        !rst_n |=> (!e_o && !q_o && !cref_o && (phase_o == '0))); // R1

    AST_CREF_HALF: assert property (@(posedge clk_m) disable iff (!rst_n)
        (c_arm && (cref_o != c_d)) |-> (c_len == 8'(HALF_C))); // R2

    AST_E_WHOLE_HALF: assert property (@(posedge clk_m) disable iff (!rst_n)
        (e_arm && (e_o != e_d)) |-> ((e_len == 8'(HALF_S)) || (e_len == 8'(HALF_F)))); // R7

    AST_Q_HIGH_AT_E_RISE: assert property (@(posedge clk_m) disable iff (!rst_n)
        $rose(e_o) |-> q_o); // R5

    AST_Q_LOW_AT_E_FALL: assert property (@(posedge clk_m) disable iff (!rst_n)
        $fell(e_o) |-> !q_o); // R5

    AST_PHASE_ZERO: assert property (@(posedge clk_m) disable iff (!rst_n)
        ($past(rst_n) && (e_o != $past(e_o))) |-> (phase_o == '0)); // R6

    AST_PHASE_STEP: assert property (@(posedge clk_m) disable iff (!rst_n)
        ($past(rst_n) && (e_o == $past(e_o))) |-> (phase_o == HW'($past(phase_o) + 1'b1))); // R6

    AST_E_ON_CREF_FALL: assert property (@(posedge clk_m) disable iff (!rst_n)
        ($past(rst_n) && (e_o != $past(e_o))) |-> $fell(cref_o)); // R9

endmodule

bind sysclk_eq_gen sysclk_eq_chk #(
    .CREF_DIV (CREF_DIV),
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .HW       ($clog2(CREF_DIV*SLOW_DIV/2))
) u_chk (
    .clk_m   (clk_m),
    .rst_n   (rst_n),
    .cref_o  (cref_o),
    .e_o     (e_o),
    .q_o     (q_o),
    .phase_o (phase_o)
);

// File: tb/tb_sysclk_eq_gen.sv
// Directed bench for sysclk_eq_gen: one task per scenario, samples on negedge.
module tb_sysclk_eq_gen;
    localparam int CLK_P = 10;
    localparam int HS    = 16;
    localparam int HF    = 8;

    logic       clk_m   = 1'b0;
    logic       rst_n   = 1'b0;
    logic       speed_i = 1'b0;
    logic       cref_o;
    logic       e_o;
    logic       q_o;
    logic [3:0] phase_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk_m = ~clk_m;

    sysclk_eq_gen dut (
        .clk_m   (clk_m),
        .rst_n   (rst_n),
        .speed_i (speed_i),
        .cref_o  (cref_o),
        .e_o     (e_o),
        .q_o     (q_o),
        .phase_o (phase_o)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(int s);
        case (s)
            0:       return e_o;
            1:       return q_o;
            default: return cref_o;
        endcase
    endfunction

    // Length of the next complete run of the selected signal at level lvl.
    task automatic run_len(int s, logic lvl, output int n);
        while (pick(s) == lvl) @(negedge clk_m);
        while (pick(s) != lvl) @(negedge clk_m);
        n = 0;
        while (pick(s) == lvl) begin n++; @(negedge clk_m); end
    endtask

    // Remaining length of the run in progress, counting the current sample.
    task automatic count_cur(int s, logic lvl, output int n);
        n = 0;
        while (pick(s) == lvl) begin n++; @(negedge clk_m); end
    endtask

    // Master clocks from a Q transition to the matching E transition.
    task automatic lead(logic lvl, output int n);
        while (q_o == lvl) @(negedge clk_m);
        while (q_o != lvl) @(negedge clk_m);
        n = 0;
        while (e_o != lvl) begin n++; @(negedge clk_m); end
    endtask

    task automatic sync_rise();
        while (e_o)  @(negedge clk_m);
        while (!e_o) @(negedge clk_m);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0; speed_i = 1'b0;
        repeat (5) @(negedge clk_m);
        check_eq("R1 e_o in reset", int'(e_o), 0);
        check_eq("R1 q_o in reset", int'(q_o), 0);
        check_eq("R1 cref_o in reset", int'(cref_o), 0);
        check_eq("R1 phase_o in reset", int'(phase_o), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk_m); n++; end while (!e_o);
        check_eq("R3 first E rise edge", n, HS);
    endtask

    task automatic t_cref();
        int n;
        run_len(2, 1'b1, n); check_eq("R2 cref high", n, 4);
        run_len(2, 1'b0, n); check_eq("R2 cref low", n, 4);
    endtask

    task automatic t_slow();
        int n;
        run_len(0, 1'b1, n); check_eq("R3 E high slow", n, HS);
        run_len(0, 1'b0, n); check_eq("R3 E low slow", n, HS);
        run_len(1, 1'b1, n); check_eq("R5 Q high slow", n, HS);
        lead(1'b1, n);       check_eq("R5 Q rise lead slow", n, HS/2);
        lead(1'b0, n);       check_eq("R5 Q fall lead slow", n, HS/2);
    endtask

    task automatic t_phase();
        int bad_hi = 0;
        int bad_lo = 0;
        logic prev_c;
        logic r9_fell;
        while (e_o) @(negedge clk_m);
        prev_c = cref_o;
        while (!e_o) begin prev_c = cref_o; @(negedge clk_m); end
        r9_fell = prev_c && !cref_o;
        check_eq("R9 cref falls with E rise", int'(r9_fell), 1);
        for (int i = 0; i < HS; i++) begin
            if (!e_o || (int'(phase_o) != i)) bad_hi++;
            @(negedge clk_m);
        end
        for (int i = 0; i < HS; i++) begin
            if (e_o || (int'(phase_o) != i)) bad_lo++;
            @(negedge clk_m);
        end
        check_eq("R6 phase count E high mismatches", bad_hi, 0);
        check_eq("R6 phase count E low mismatches", bad_lo, 0);
    endtask

    task automatic t_fast();
        int n;
        speed_i = 1'b1;
        sync_rise();
        while (e_o) @(negedge clk_m);
        run_len(0, 1'b1, n); check_eq("R4 E high fast", n, HF);
        run_len(0, 1'b0, n); check_eq("R4 E low fast", n, HF);
        lead(1'b1, n);       check_eq("R5 Q rise lead fast", n, HF/2);
        lead(1'b0, n);       check_eq("R5 Q fall lead fast", n, HF/2);
    endtask

    // Speed drops to slow in the middle of a fast E-high half.
    task automatic t_change_in_high();
        int n = 0;
        sync_rise();
        for (int k = 0; k < 3; k++) begin n++; @(negedge clk_m); end
        speed_i = 1'b0;
        while (e_o) begin n++; @(negedge clk_m); end
        check_eq("R7 fast E high kept on mid change", n, HF);
        count_cur(0, 1'b0, n); check_eq("R7 E low after fall is slow", n, HS);
        count_cur(0, 1'b1, n); check_eq("R7 E high following is slow", n, HS);
    endtask

    // Speed flips in the sample right before the edge where E falls.
    task automatic t_coincide();
        int n = 0;
        sync_rise();
        while (e_o) begin
            if (int'(phase_o) == HS - 1) speed_i = 1'b1;
            n++;
            @(negedge clk_m);
        end
        check_eq("R8 E high ending at switch edge", n, HS);
        count_cur(0, 1'b0, n); check_eq("R8 E low starting at switch edge", n, HF);
    endtask

    // Speed flips one sample after E fell: waits a full period.
    task automatic t_change_after_fall();
        int n;
        while (e_o) @(negedge clk_m);
        speed_i = 1'b0;
        count_cur(0, 1'b0, n); check_eq("R7 E low after late change", n, HF);
        count_cur(0, 1'b1, n); check_eq("R7 E high after late change", n, HF);
        count_cur(0, 1'b0, n); check_eq("R7 E low at next fall", n, HS);
    endtask

    initial begin
        @(negedge clk_m);
        t_reset();
        t_cref();
        t_slow();
        t_phase();
        t_fast();
        t_change_in_high();
        t_coincide();
        t_change_after_fall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule